// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block holds two timer/counter channels. Each channel has a low byte and a high byte, and a 4-bit configuration nibble sets how the channel behaves. A channel counts either ticks of an internal divide-by-12 machine-cycle strobe or falling edges seen on its own event pin. It counts only while its run bit is set, and when gating is enabled it also needs its gate pin to be high. Because the gate pin switches counting on and off, the channel can measure how long a pulse lasts.

The mode field inside the nibble selects one of four counting shapes:
- a 13-bit counter, in which five low bits act as a prescaler in front of the high byte;
- a full 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split arrangement, in which channel 0 becomes two independent 8-bit timers and channel 1 is frozen.

Software drives the block through a flat write port. It loads the configuration, the run bits and the count bytes, and it clears the overflow flags. The counts and flags appear directly on output ports.

Each event pin feeds a two-state machine with the states EV_LOW and EV_HIGH. The machine samples the pin only on a machine-cycle tick:
- on a tick, a high sample moves it to EV_HIGH;
- on a tick, a low sample moves it to EV_LOW;
- the move from EV_HIGH to EV_LOW is the counted event.

The mode itself is a stored field, not a sequencer. Its four values are MD_13BIT, MD_16BIT, MD_RELOAD and MD_SPLIT.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both counts read 0, both flags read 0 and both run bits are 0, so no count changes until software starts a channel.
- R2: With the counter/timer select bit at 0, a running channel adds exactly one count per 12 input clocks. A channel whose run bit is 0 holds its count.
- R3: Mode 1 (mode field 2'b01) counts over the full 16 bits. The step from FFFFh to 0000h sets that channel's flag.
- R4: Mode 0 (mode field 2'b00) counts in bits [4:0] of the low byte and carries into the high byte when those bits wrap from 1Fh. Bits [7:5] of the low byte are left alone. The flag sets when the high byte is FFh and the five low bits are 1Fh.
- R5: Mode 2 (mode field 2'b10) counts in the low byte only. A step from FFh loads the low byte with the high byte and sets the flag.
- R6: When channel 0 is in mode 3 (mode field 2'b11), its low byte is an 8-bit timer under run bit 0 that sets flag 0 when it wraps. Its high byte is an 8-bit timer that counts internal ticks under run bit 1 and sets flag 1 when it wraps.
- R7: Channel 1 in mode 3 holds its count and counts again once it is moved to another mode. While channel 0 is in mode 3, channel 1's own wraps do not set flag 1.
- R8: With the counter/timer select bit at 1, the event pin is sampled once per machine cycle. A high sample followed by a low sample adds exactly one count.
- R9: With the gate bit set, a channel counts only while its run bit is 1 and its gate pin is high.
- R10: A flag stays set until software writes a 0 to it. Writing 1 leaves the flag unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R11: Write address map:
  - address 0 takes the configuration nibbles, channel 0 in bits [3:0] and channel 1 in bits [7:4]. Within a nibble, bit 3 is gate, bit 2 is the counter/timer select and bits [1:0] are the mode.
  - address 1 takes the control byte: bits [1:0] are the run bits and bits [3:2] are the flag-clear bits for flags 0 and 1.
  - addresses 2 to 5 load the count bytes in the order channel 0 low, channel 0 high, channel 1 low, channel 1 high. A byte write takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ev_pin | input | 2 | Event inputs, one per channel |
| gate_pin | input | 2 | Gate inputs, one per channel |
| count0 | output | 16 | Channel 0 count, high byte above low byte |
| count1 | output | 16 | Channel 1 count, high byte above low byte |
| ovf_flag | output | 2 | Overflow flags, bit i for flag i |

## Verification
Register writes take effect at the clock edge of the write, and an increment appears at the edge of the tick that causes it. The tick phase runs freely, so the bench does not chase it. It opens every run window on one write edge and closes it on the edge exactly 12·N clocks later, which guarantees N ticks whatever the phase is.

A change on a gate or event pin passes two synchronizer flops before it has any effect. To absorb this, the bench holds each gate window for a whole multiple of 12 clocks and each event level for 24 clocks, so every level is sampled by two ticks. For the test where an overflow meets a flag clear in the same cycle, the bench first watches the count step once to find the tick phase. It then places the clear on the edge 12 clocks later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_13BIT  = 2'd0,
        MD_16BIT  = 2'd1,
        MD_RELOAD = 2'd2,
        MD_SPLIT  = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;

    typedef enum logic {
        EV_LOW  = 1'b0,
        EV_HIGH = 1'b1
    } ev_state_e;

    localparam logic [2:0] ADR_CFG  = 3'd0;
    localparam logic [2:0] ADR_CTRL = 3'd1;
    localparam logic [2:0] ADR_LO0  = 3'd2;

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = (div_q == CW'(DIV - 1));

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic pulse_o
);
    ev_state_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_LOW;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        if (tick_i) begin
            state_n = pin_i ? EV_HIGH : EV_LOW;
        end
    end

    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            EV_HIGH: pulse_o = tick_i && !pin_i;
            EV_LOW:  pulse_o = 1'b0;
        endcase
    end

    AST_EDGE_RETURNS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> (state_q == EV_LOW)); // R8

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int BW    = 8,
    parameter int PRE_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_mode_e     mode_i,
    input  logic          inc_i,
    input  logic          hi_inc_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] lo_o,
    output logic [BW-1:0] hi_o,
    output logic          ovf_o,
    output logic          hi_ovf_o
);
    logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    always_comb begin
        lo_n     = lo_q;
        hi_n     = hi_q;
        ovf_o    = 1'b0;
        hi_ovf_o = 1'b0;
        unique case (mode_i)
            MD_13BIT: if (inc_i) begin
                lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
                if (&lo_q[PRE_W-1:0]) begin
                    hi_n  = hi_q + 1'b1;
                    ovf_o = &hi_q;
                end
            end
            MD_16BIT: if (inc_i) begin
                {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                ovf_o        = &{hi_q, lo_q};
            end
            MD_RELOAD: if (inc_i) begin
                if (&lo_q) begin
                    lo_n  = hi_q;
                    ovf_o = 1'b1;
                end else begin
                    lo_n = lo_q + 1'b1;
                end
            end
            MD_SPLIT: begin
                if (inc_i) begin
                    lo_n  = lo_q + 1'b1;
                    ovf_o = &lo_q;
                end
                if (hi_inc_i) begin
                    hi_n     = hi_q + 1'b1;
                    hi_ovf_o = &hi_q;
                end
            end
        endcase
        if (wr_lo_i) lo_n = wdata_i;
        if (wr_hi_i) hi_n = wdata_i;
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    AST_RELOAD_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_RELOAD && ovf_o && !wr_lo_i) |=> (lo_q == $past(hi_q))); // R5
    AST_WIDE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_16BIT && ovf_o && !wr_lo_i && !wr_hi_i) |=> ({hi_q, lo_q} == '0)); // R3

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DIV   = 12,
    parameter int PRE_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  ev_pin,
    input  logic [1:0]  gate_pin,
    output logic [15:0] count0,
    output logic [15:0] count1,
    output logic [1:0]  ovf_flag
);
    localparam int NCH = 2;
    localparam int BW  = 8;

    tmr_cfg_t       cfg_q [NCH];
    logic [NCH-1:0] run_q, flag_q, flag_n;
    logic [NCH-1:0] ev_s1, ev_s2, gt_s1, gt_s2;
    logic [NCH-1:0] ev_pulse, src, en, inc, hi_inc, ovf, hi_ovf, set;
    logic [BW-1:0]  lo [NCH];
    logic [BW-1:0]  hi [NCH];
    logic           tick, ctrl_wr, split0;

    assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
    assign split0  = (cfg_q[0].mode == MD_SPLIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_s1 <= '0;
            ev_s2 <= '0;
            gt_s1 <= '0;
            gt_s2 <= '0;
        end else begin
            ev_s1 <= ev_pin;
            ev_s2 <= ev_s1;
            gt_s1 <= gate_pin;
            gt_s2 <= gt_s1;
        end
    end

    tmr_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    always_comb begin
        set[0] = ovf[0];
        set[1] = split0 ? hi_ovf[0] : ovf[1];
        for (int i = 0; i < NCH; i++) begin
            flag_n[i] = (ctrl_wr ? (flag_q[i] & wr_data[2+i]) : flag_q[i]) | set[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_en && wr_addr == ADR_CFG) begin
                for (int i = 0; i < NCH; i++) cfg_q[i] <= tmr_cfg_t'(wr_data[4*i +: 4]);
            end
            if (ctrl_wr) run_q <= wr_data[NCH-1:0];
            flag_q <= flag_n;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .pin_i   (ev_s2[g]),
            .pulse_o (ev_pulse[g])
        );

        assign src[g] = cfg_q[g].ext_sel ? ev_pulse[g] : tick;
        assign en[g]  = run_q[g] && (!cfg_q[g].gate || gt_s2[g]);

        if (g == 0) begin : g_main
            assign inc[g]    = src[g] && en[g];
            assign hi_inc[g] = tick && run_q[1];
        end else begin : g_side
            assign inc[g]    = src[g] && en[g] && (cfg_q[g].mode != MD_SPLIT);
            assign hi_inc[g] = 1'b0;
        end

        tmr_core #(.BW(BW), .PRE_W(PRE_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (cfg_q[g].mode),
            .inc_i    (inc[g]),
            .hi_inc_i (hi_inc[g]),
            .wr_lo_i  (wr_en && wr_addr == ADR_LO0 + 3'(2*g)),
            .wr_hi_i  (wr_en && wr_addr == ADR_LO0 + 3'(2*g + 1)),
            .wdata_i  (wr_data),
            .lo_o     (lo[g]),
            .hi_o     (hi[g]),
            .ovf_o    (ovf[g]),
            .hi_ovf_o (hi_ovf[g])
        );
    end

    assign count0   = {hi[0], lo[0]};
    assign count1   = {hi[1], lo[1]};
    assign ovf_flag = flag_q;

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == '0 && !wr_en) |=> $stable(count0)); // R2
    AST_SIDE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1].mode == MD_SPLIT && !wr_en) |=> $stable(count1)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag[0] && !ctrl_wr) |=> ovf_flag[0]); // R10
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0].gate && !gt_s2[0] && !split0 && !wr_en) |=> $stable(count0)); // R9

endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  ev_pin = '0;
    logic [1:0]  gate_pin = '0;
    logic [15:0] count0, count1;
    logic [1:0]  ovf_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr_pair u_tmr_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ev_pin   (ev_pin),
        .gate_pin (gate_pin),
        .count0   (count0),
        .count1   (count1),
        .ovf_flag (ovf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int ch, input logic [15:0] v);
        wr(3'(2 + 2*ch), v[7:0]);
        wr(3'(3 + 2*ch), v[15:8]);
    endtask

    // run bits on for exactly n ticks; flags preserved when closing
    task automatic window(input logic [7:0] ctrl, input int n);
        wr(3'd1, ctrl);
        repeat (12*n - 1) @(negedge clk);
        wr(3'd1, 8'h0C);
    endtask

    task automatic t_reset;
        chk("R1 count0", count0, 16'h0);
        chk("R1 count1", count1, 16'h0);
        chk("R1 flags", ovf_flag, 2'b00);
        repeat (40) @(negedge clk);
        chk("R1 idle count0", count0, 16'h0);
    endtask

    task automatic t_timer;
        wr(3'd0, 8'h11);
        load(1, 16'h1234);
        chk("R11 byte load", count1, 16'h1234);
        load(0, 16'h0000);
        window(8'h0D, 5);
        chk("R2 five ticks", count0, 16'd5);
        repeat (40) @(negedge clk);
        chk("R2 stopped holds", count0, 16'd5);
    endtask

    task automatic t_wide;
        load(0, 16'hFFFE);
        window(8'h0D, 3);
        chk("R3 wrap count", count0, 16'h0001);
        chk("R3 flag0", ovf_flag[0], 1'b1);
        repeat (30) @(negedge clk);
        chk("R10 flag sticky", ovf_flag[0], 1'b1);
        wr(3'd1, 8'h08);
        chk("R10 flag cleared", ovf_flag[0], 1'b0);
    endtask

    task automatic t_13bit;
        wr(3'd0, 8'h10);
        wr(3'd2, 8'hFE);
        wr(3'd3, 8'h12);
        window(8'h0D, 3);
        chk("R4 prescale carry", count0, 16'h13E1);
        chk("R4 no flag", ovf_flag[0], 1'b0);
        wr(3'd2, 8'h1F);
        wr(3'd3, 8'hFF);
        window(8'h0D, 1);
        chk("R4 wrap count", count0, 16'h0000);
        chk("R4 flag0", ovf_flag[0], 1'b1);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_reload;
        wr(3'd0, 8'h12);
        wr(3'd2, 8'hFE);
        wr(3'd3, 8'h80);
        window(8'h0D, 4);
        chk("R5 reloaded count", count0, 16'h8082);
        chk("R5 flag0", ovf_flag[0], 1'b1);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_split;
        wr(3'd0, 8'h13);
        load(0, 16'hFEFE);
        load(1, 16'h1234);
        window(8'h0D, 3);
        chk("R6 low half", count0, 16'hFE01);
        chk("R6 flag0 from low", ovf_flag, 2'b01);
        wr(3'd1, 8'h00);
        window(8'h0E, 3);
        chk("R6 high half", count0, 16'h0101);
        chk("R6 flag1 from high", ovf_flag, 2'b10);
        chk("R7 ch1 other mode counts", count1, 16'h1237);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h00);
        load(1, 16'hFFFF);
        window(8'h0E, 1);
        chk("R7 ch1 wrapped", count1, 16'h0000);
        chk("R7 ch1 wrap no flag1", ovf_flag[1], 1'b0);
    endtask

    task automatic t_frozen;
        wr(3'd0, 8'h31);
        load(0, 16'h0000);
        load(1, 16'h0055);
        window(8'h0F, 4);
        chk("R7 ch1 frozen", count1, 16'h0055);
        chk("R2 ch0 alongside", count0, 16'd4);
        wr(3'd0, 8'h11);
        window(8'h0E, 2);
        chk("R7 ch1 restarted", count1, 16'h0057);
    endtask

    task automatic t_events;
        wr(3'd0, 8'h15);
        load(0, 16'h0000);
        wr(3'd1, 8'h0D);
        ev_pin[0] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            repeat (24) @(negedge clk);
            ev_pin[0] = 1'b0;
            repeat (24) @(negedge clk);
            ev_pin[0] = 1'b1;
        end
        repeat (24) @(negedge clk);
        wr(3'd1, 8'h0C);
        chk("R8 three falling edges", count0, 16'd3);
        ev_pin[0] = 1'b0;
    endtask

    task automatic t_gate;
        wr(3'd0, 8'h19);
        load(0, 16'h0000);
        wr(3'd1, 8'h0D);
        repeat (60) @(negedge clk);
        chk("R9 gate low blocks", count0, 16'd0);
        gate_pin[0] = 1'b1;
        repeat (48) @(negedge clk);
        gate_pin[0] = 1'b0;
        repeat (30) @(negedge clk);
        wr(3'd1, 8'h0C);
        chk("R9 gated window", count0, 16'd4);
    endtask

    task automatic t_clear_race;
        int guard;
        wr(3'd0, 8'h11);
        wr(3'd1, 8'h00);
        load(0, 16'hFFFE);
        wr(3'd1, 8'h0D);
        guard = 0;
        while (count0 != 16'hFFFF && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        repeat (11) @(negedge clk);
        wr(3'd1, 8'h09);
        chk("R10 wrap count", count0, 16'h0000);
        chk("R10 overflow beats clear", ovf_flag[0], 1'b1);
        wr(3'd1, 8'h08);
        chk("R10 later clear", ovf_flag[0], 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timer();
        t_wide();
        t_13bit();
        t_reload();
        t_split();
        t_frozen();
        t_events();
        t_gate();
        t_clear_race();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule